// File: doc/BRIEF.md
# Fracturable Lookup-Table Logic Element

This block is one configurable logic element of a programmable fabric. It takes six data inputs and drives two data outputs from a single clock. A mode bit chooses how the stored truth table is used. In dual mode, the table is split into two 5-input functions that read the same five low inputs. In single mode, the whole table forms one 6-input function on output 0, and output 1 is tied low.

Each output can come straight from its lookup result or from a flip-flop that captures that result on the clock edge. A per-output select bit picks between the two. The truth table, the mode bit and the two select bits sit in a static configuration shift register. That register is loaded one bit per clock while a load enable is high, and it keeps its contents at all other times. The last stage of the register is brought out, so several elements can be daisy-chained. The output flip-flops clear under a synchronous active-high reset. The configuration register has no reset.

Top module: `fle_top`

## Requirements
- R1: While `cfg_en` is high, each clock shifts the configuration register by one position: `cfg_din` enters bit 0 and `cfg_dout` shows the top bit. After 67 shifts, the first bit shifted in is at the top. For the default size, the layout is: bits 63:0 hold the truth table, bit 64 holds the mode (0 = dual, 1 = single), bit 65 selects output 0 and bit 66 selects output 1. For each select bit, 1 means registered and 0 means combinational.
- R2: While `cfg_en` is low, the configuration does not change, whatever `cfg_din` does.
- R3: In dual mode, combinational output 0 equals truth-table bit `din[4:0]`, read from bits 31:0.
- R4: In dual mode, combinational output 1 equals bit `32 + din[4:0]`. In dual mode, `din[5]` has no effect on either output.
- R5: In single mode, combinational output 0 equals truth-table bit `din[5:0]`, read from bits 63:0, with `din[0]` as the least significant index bit.
- R6: In single mode, output 1 is 0, whether it is taken combinational or registered.
- R7: An output set to registered shows the lookup result that was present at the previous rising clock edge.
- R8: A synchronous reset clears both output flip-flops. A registered output reads 0 in the cycle after a reset edge, even when its lookup result is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output flip-flops and the configuration register |
| rst | input | 1 | Synchronous active-high reset of the output flip-flops |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (top bit of the register) |
| din | input | 6 | Lookup-table data inputs |
| dout | output | 2 | Element outputs |

## Verification
The bench builds the element with its default size of 5-input halves. This gives a 64-bit table and a 67-bit configuration register, so every input vector can be applied under every configuration that is loaded. Five configurations are used: each mode with combinational outputs, each mode with registered outputs, and a mixed case with one output registered and one combinational. For each configuration, all 64 input values are applied. Every response is predicted by indexing the table that was shifted in. Reloading the register checks the serial data out bit by bit against the previous load.

// File: rtl/fle_pkg.sv
package fle_pkg;

    typedef enum logic {
        MODE_DUAL   = 1'b0,
        MODE_SINGLE = 1'b1
    } fle_mode_e;

    typedef enum logic {
        OSEL_COMB = 1'b0,
        OSEL_REG  = 1'b1
    } fle_osel_e;

    // Full configuration width for halves of k inputs: table, mode, two selects.
    function automatic int cfg_width(input int k);
        return (2 ** (k + 1)) + 3;
    endfunction

endpackage

// File: rtl/fle_cfg_chain.sv
module fle_cfg_chain #(
    parameter int WIDTH = 67
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] bits,
    output logic             ser_out
);
    logic [WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (shift_en) begin
            chain_q <= {chain_q[WIDTH-2:0], ser_in};
        end
    end

    assign bits    = chain_q;
    assign ser_out = chain_q[WIDTH-1];

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(chain_q));

    // R1
    cfg_shift_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (chain_q[0] == $past(ser_in)));

endmodule

// File: rtl/fle_lut.sv
module fle_lut #(
    parameter int K = 5
) (
    input  logic [(2**K)-1:0] table_bits,
    input  logic [K-1:0]      sel,
    output logic              y
);
    assign y = table_bits[sel];
endmodule

// File: rtl/fle_out_stage.sv
module fle_out_stage
    import fle_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      d,
    input  fle_osel_e osel,
    output logic      y
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign y = (osel == OSEL_REG) ? q : d;

    // R7
    reg_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (osel == OSEL_REG) |=> (y == $past(d)) || (osel != OSEL_REG));

    // R8
    reg_reset_chk: assert property (@(posedge clk)
        rst |=> (q == 1'b0));

endmodule

// File: rtl/fle_top.sv
module fle_top
    import fle_pkg::*;
#(
    parameter int LUT_K = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_en,
    input  logic               cfg_din,
    output logic               cfg_dout,
    input  logic [LUT_K:0]     din,
    output logic [1:0]         dout
);
    localparam int HALF_W  = 2 ** LUT_K;
    localparam int TBL_W   = 2 * HALF_W;
    localparam int CFG_W   = cfg_width(LUT_K);
    localparam int MODE_B  = TBL_W;
    localparam int SEL0_B  = TBL_W + 1;

    logic [CFG_W-1:0] cfg_bits;
    fle_mode_e        mode;
    logic [1:0]       half_y;
    logic [1:0]       pre_y;

    fle_cfg_chain #(.WIDTH(CFG_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .ser_in   (cfg_din),
        .bits     (cfg_bits),
        .ser_out  (cfg_dout)
    );

    assign mode = fle_mode_e'(cfg_bits[MODE_B]);

    for (genvar h = 0; h < 2; h++) begin : g_half
        fle_lut #(.K(LUT_K)) u_lut (
            .table_bits (cfg_bits[h*HALF_W +: HALF_W]),
            .sel        (din[LUT_K-1:0]),
            .y          (half_y[h])
        );
    end

    // Fracture: single mode uses the top input to pick a half.
    always_comb begin
        if (mode == MODE_SINGLE) begin
            pre_y[0] = din[LUT_K] ? half_y[1] : half_y[0];
            pre_y[1] = 1'b0;
        end else begin
            pre_y = half_y;
        end
    end

    for (genvar o = 0; o < 2; o++) begin : g_out
        fle_out_stage u_stage (
            .clk  (clk),
            .rst  (rst),
            .d    (pre_y[o]),
            .osel (fle_osel_e'(cfg_bits[SEL0_B + o])),
            .y    (dout[o])
        );
    end

    // R6
    single_out1_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SINGLE && !cfg_en && $stable(mode)) |=> (mode != MODE_SINGLE) || (dout[1] == 1'b0));

endmodule

// File: tb/tb_fle_top.sv
module tb_fle_top;
    localparam int CW = 67;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_dout;
    logic [5:0] din = '0;
    logic [1:0] dout;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] cur_cfg = '0;
    bit cfg_valid = 0;

    always #5 clk = ~clk;

    fle_top dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .din(din), .dout(dout)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected combinational lookup result per requirement text.
    function automatic logic [1:0] expect_lut(input logic [CW-1:0] c, input logic [5:0] v);
        logic [1:0] r;
        if (c[64]) begin
            r[0] = c[v];
            r[1] = 1'b0;
        end else begin
            r[0] = c[{1'b0, v[4:0]}];
            r[1] = c[32 + int'(v[4:0])];
        end
        return r;
    endfunction

    // R1: shift new config MSB first, checking serial out against the old one.
    task automatic load_cfg(input logic [CW-1:0] c);
        for (int i = 0; i < CW; i++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = c[CW-1-i];
            #1;
            if (cfg_valid) chk("R1 serial out", {1'b0, cfg_dout}, {1'b0, cur_cfg[CW-1-i]});
        end
        @(negedge clk);
        cfg_en = 1'b0;
        cur_cfg = c;
        cfg_valid = 1;
    endtask

    // Sweep all inputs; check combinational view after drive, registered view after edge.
    task automatic sweep(input string req);
        logic [1:0] prev_e;
        logic [1:0] now_e;
        logic [1:0] mix;
        @(negedge clk);
        din = 6'd63;
        @(posedge clk);
        prev_e = expect_lut(cur_cfg, 6'd63);
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            din = 6'(v);
            cfg_din = ~cfg_din;
            now_e = expect_lut(cur_cfg, 6'(v));
            #1;
            mix[0] = cur_cfg[65] ? prev_e[0] : now_e[0];
            mix[1] = cur_cfg[66] ? prev_e[1] : now_e[1];
            chk(req, dout, mix);
            @(posedge clk);
            #1;
            chk({req, " R7 after edge"}, dout, now_e);
            prev_e = now_e;
        end
    endtask

    function automatic logic [63:0] mk_tbl(input int seed);
        logic [63:0] t;
        for (int i = 0; i < 64; i++) t[i] = ((i * seed + (i >> 2) + seed) % 3) == 1;
        return t;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state of flops; with unloaded config only flops matter, check after load.
        @(negedge clk);
        rst = 1'b0;

        // R3 R4: dual mode, combinational
        load_cfg({1'b0, 1'b0, 1'b0, mk_tbl(7)});
        sweep("R3/R4 dual comb");
        // R2: toggled cfg_din during sweep with cfg_en low; re-sweep proves hold
        sweep("R2 hold");
        // R7: dual registered
        load_cfg({1'b1, 1'b1, 1'b0, mk_tbl(11)});
        sweep("R7 dual reg");
        // R5 R6: single comb
        load_cfg({1'b0, 1'b0, 1'b1, mk_tbl(5)});
        sweep("R5/R6 single comb");
        // R6: single, both registered
        load_cfg({1'b1, 1'b1, 1'b1, mk_tbl(13)});
        sweep("R6 single reg");
        // R4: dual, output 0 registered, output 1 combinational
        load_cfg({1'b0, 1'b1, 1'b0, ~mk_tbl(3)});
        sweep("R4 dual mixed");

        // R8: all-ones table, registered; reset must clear flops
        load_cfg({1'b1, 1'b1, 1'b0, {64{1'b1}}});
        @(negedge clk);
        din = 6'd9;
        @(posedge clk);
        #1;
        chk("R8 pre-reset ones", dout, 2'b11);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 reset clears", dout, 2'b00);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 held after reset", dout, 2'b00);
        @(posedge clk);
        #1;
        chk("R8 recapture", dout, 2'b11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule